// File: doc/BRIEF.md
# Serial GPIO expander controller

This block extends a chip's general-purpose pins over a four-wire serial link. One chain of external serial-to-parallel latches provides the outputs. One chain of external parallel-to-serial registers provides the inputs. Both chains share a shift clock and an active-low load/shift line. The block scans both chains continuously, one frame after another. In each frame it parallel-loads the input chain, shifts the pending output image out while it shifts the input image in, and then pulses the load/shift line so that the output latches update. The line counts `N_IN` and `N_OUT` are separate parameters, each from 0 to 64. A line is only an input or only an output.

A host reads and writes the block through a plain register port. Every write is accepted in the cycle it is presented and reads are combinational, so there is no back-pressure at any point. The shift clock is the system clock divided by a programmable half-period. Each input has an interrupt enable and a two-bit sensitivity. Every input is checked once per frame against its previous image, and the sticky status bits are ORed into a single interrupt output.

Top module: `serial_gpio_expander`

## Requirements
- R1: While `ser_load_n` is low, `ser_clk` is low. `ser_clk` rises only while `ser_load_n` is high. `ser_dout` changes only while `ser_clk` is low.
- R2: The divider register (offset 0, reset value 2) sets the phase length H in system clocks. A value of 0 acts as 1. Each high phase of `ser_clk` and each low pulse of `ser_load_n` lasts exactly H clocks.
- R3: A frame has the following steps in order. First, `ser_load_n` is low for one phase. Next, `ser_load_n` returns high and L = max(N_IN, N_OUT) rising edges of `ser_clk` follow. Finally, `ser_load_n` goes low for one phase and then returns high. The output latches update on each rising edge of `ser_load_n`.
- R4: The first bit of a frame on `ser_dout` is bit L-1 of the output image, and the bits follow in descending order. Bits at or above N_OUT are sent as 0. After a frame, external latch i therefore holds output bit i.
- R5: A write to the output image is snapshotted only at a frame boundary. A write made during the shift of frame F reaches the latches at the end of frame F+1, and the latches at the end of frame F still show the old value.
- R6: `ser_din` is sampled as `ser_clk` rises. The first sample is input N_IN-1. The readable input image changes only at the end of a complete frame, and its bits at or above N_IN read 0.
- R7: Each input k has a 2-bit sensitivity field at word 7 + k/16, bits 2*(k%16)+1 down to 2*(k%16). The codes are 0 level-high, 1 level-low, 2 rising edge (previous image 0, new image 1) and 3 falling edge.
- R8: A status bit is set only if the input's enable bit is 1. A disabled input never sets status.
- R9: Status bits are sticky and are cleared by writing 1 to them. A level condition that still holds sets the bit again at every frame end. Edge bits stay clear until a new edge occurs.
- R10: `irq_o` is high exactly when at least one status bit is set.
- R11: The register map is: 0 divider, 1 and 2 output image bits 31:0 and 63:32, 3 and 4 input image (read-only), 5 and 6 enables, 7 to 10 sensitivity, 11 and 12 status (write 1 to clear). Bits beyond the configured line count read 0.
- R12: After reset, all registers read 0 except the divider, which reads 2. Also `irq_o` is 0, `ser_clk` is 0 and the first frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 4 | Register word offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational from host_addr |
| ser_clk | output | 1 | Shift clock to both external chains |
| ser_load_n | output | 1 | Low: parallel-load the inputs; rising edge: latch the outputs |
| ser_dout | output | 1 | Serial output data |
| ser_din | input | 1 | Serial input data |
| irq_o | output | 1 | Combined interrupt |

## Verification
Serial results are due in frames, not in clocks. The bench never counts clocks from a write. It counts falling edges of `ser_load_n`, two per frame, and samples three clocks after the edge it is waiting for. An output written during a shift is checked after the end-of-frame pulse of the current frame, where the old value is expected, and again one frame later, where the new value is expected. An input change made during a shift is checked in the same two steps. The divider is checked by counting clocks inside one phase, and interrupt status is read once at least two full frames have passed since the input change.

// File: rtl/sgx_pkg.sv
package sgx_pkg;

  typedef enum logic [1:0] {
    SENSE_HIGH = 2'd0,
    SENSE_LOW  = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_FALL = 2'd3
  } sense_e;

  typedef enum logic [2:0] {
    PH_LOAD,
    PH_SETUP,
    PH_HIGH,
    PH_LOW,
    PH_LATLO,
    PH_LATHI
  } phase_e;

  localparam int REG_AW    = 4;
  localparam int REG_DW    = 32;
  localparam int MAX_LINES = 64;

  localparam logic [REG_AW-1:0] ADR_DIV    = 4'd0;
  localparam logic [REG_AW-1:0] ADR_OUT_LO = 4'd1;
  localparam logic [REG_AW-1:0] ADR_OUT_HI = 4'd2;
  localparam logic [REG_AW-1:0] ADR_IN_LO  = 4'd3;
  localparam logic [REG_AW-1:0] ADR_IN_HI  = 4'd4;
  localparam logic [REG_AW-1:0] ADR_EN_LO  = 4'd5;
  localparam logic [REG_AW-1:0] ADR_EN_HI  = 4'd6;
  localparam logic [REG_AW-1:0] ADR_SNS0   = 4'd7;
  localparam logic [REG_AW-1:0] ADR_SNS3   = 4'd10;
  localparam logic [REG_AW-1:0] ADR_ST_LO  = 4'd11;
  localparam logic [REG_AW-1:0] ADR_ST_HI  = 4'd12;

endpackage

// File: rtl/sgx_clkdiv.sv
module sgx_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_period,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  // a zero setting behaves as one clock per phase
  assign limit = (half_period == '0) ? ONE : half_period;
  assign tick  = (cnt >= limit - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + ONE;
  end
endmodule

// File: rtl/sgx_scan_engine.sv
module sgx_scan_engine
  import sgx_pkg::*;
#(
  parameter int N_IN  = 16,
  parameter int N_OUT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [OW-1:0] out_img,
  input  logic          ser_din,
  output logic          ser_clk,
  output logic          ser_load_n,
  output logic          ser_dout,
  output logic          frame_done,
  output logic [IW-1:0] cap_img
);
  localparam int IW  = (N_IN  > 0) ? N_IN  : 1;
  localparam int OW  = (N_OUT > 0) ? N_OUT : 1;
  localparam int LMX = (N_IN > N_OUT) ? N_IN : N_OUT;
  localparam int L   = (LMX > 0) ? LMX : 1;
  localparam int CW  = $clog2(L + 1);
  localparam logic [CW-1:0] LAST = CW'(L - 1);

  phase_e        ph;
  logic [L-1:0]  sh;
  logic [L-1:0]  cap;
  logic [L-1:0]  out_ext;
  logic [CW-1:0] bitn;
  logic          clk_q, ld_q, done_q;

  generate
    if (N_OUT > 0) begin : g_out
      assign out_ext = L'(out_img);
    end else begin : g_noout
      assign out_ext = '0;
    end
    if (N_IN > 0) begin : g_in
      assign cap_img = cap[L-1 -: IW];
    end else begin : g_noin
      assign cap_img = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_LOAD;
      sh     <= '0;
      cap    <= '0;
      bitn   <= '0;
      clk_q  <= 1'b0;
      ld_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        case (ph)
          PH_LOAD: begin
            ld_q <= 1'b1;
            ph   <= PH_SETUP;
          end
          PH_SETUP: begin
            clk_q <= 1'b1;
            cap   <= (cap << 1) | L'(ser_din);
            bitn  <= '0;
            ph    <= PH_HIGH;
          end
          PH_HIGH: begin
            clk_q <= 1'b0;
            sh    <= sh << 1;
            if (bitn == LAST) begin
              ld_q <= 1'b0;
              ph   <= PH_LATLO;
            end else begin
              bitn <= bitn + CW'(1);
              ph   <= PH_LOW;
            end
          end
          PH_LOW: begin
            clk_q <= 1'b1;
            cap   <= (cap << 1) | L'(ser_din);
            ph    <= PH_HIGH;
          end
          PH_LATLO: begin
            ld_q <= 1'b1;
            ph   <= PH_LATHI;
          end
          PH_LATHI: begin
            ld_q   <= 1'b0;
            done_q <= 1'b1;
            sh     <= out_ext;   // snapshot of the output image at the frame boundary
            ph     <= PH_LOAD;
          end
          default: ph <= PH_LOAD;
        endcase
      end
    end
  end

  assign ser_clk    = clk_q;
  assign ser_load_n = ld_q;
  assign ser_dout   = sh[L-1];
  assign frame_done = done_q;
endmodule

// File: rtl/sgx_irq_unit.sv
module sgx_irq_unit
  import sgx_pkg::*;
#(
  parameter int N_IN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_done,
  input  logic [IW-1:0]   img_new,
  input  logic [IW-1:0]   img_old,
  input  logic [IW-1:0]   enable,
  input  logic [2*IW-1:0] sense,
  input  logic            clr_we,
  input  logic [IW-1:0]   clr_mask,
  output logic [IW-1:0]   status,
  output logic            irq
);
  localparam int IW = (N_IN > 0) ? N_IN : 1;
  localparam logic [IW-1:0] LIVE = (N_IN > 0) ? {IW{1'b1}} : '0;

  logic [IW-1:0] hit;

  generate
    for (genvar k = 0; k < IW; k++) begin : g_line
      sense_e mode;
      assign mode = sense_e'(sense[2*k +: 2]);
      always_comb begin
        case (mode)
          SENSE_HIGH: hit[k] =  img_new[k];
          SENSE_LOW:  hit[k] = ~img_new[k];
          SENSE_RISE: hit[k] =  img_new[k] & ~img_old[k];
          SENSE_FALL: hit[k] = ~img_new[k] &  img_old[k];
          default:    hit[k] = 1'b0;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else begin
      // a set from a frame end wins over a clear in the same cycle
      status <= (status & ~(clr_we ? clr_mask : '0))
              | (frame_done ? (hit & enable & LIVE) : '0);
    end
  end

  assign irq = |status;
endmodule

// File: rtl/serial_gpio_expander.sv
module serial_gpio_expander
  import sgx_pkg::*;
#(
  parameter int          N_IN      = 16,
  parameter int          N_OUT     = 12,
  parameter int          DIV_W     = 16,
  parameter int unsigned DIV_RESET = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [3:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        ser_clk,
  output logic        ser_load_n,
  output logic        ser_dout,
  input  logic        ser_din,
  output logic        irq_o
);
  localparam int IW = (N_IN  > 0) ? N_IN  : 1;
  localparam int OW = (N_OUT > 0) ? N_OUT : 1;
  localparam logic [63:0] IMASK = (N_IN  >= 64) ? '1 : ((64'd1 << N_IN)  - 64'd1);
  localparam logic [63:0] OMASK = (N_OUT >= 64) ? '1 : ((64'd1 << N_OUT) - 64'd1);

  logic [DIV_W-1:0] div_r;
  logic [OW-1:0]    out_r;
  logic [IW-1:0]    en_r;
  logic [2*IW-1:0]  sns_r;
  logic [IW-1:0]    in_img;
  logic [IW-1:0]    cap_img;
  logic [IW-1:0]    status;
  logic             tick, frame_done;

  logic [63:0]  out_nx, en_nx, clr64;
  logic [127:0] sns_nx;
  logic [63:0]  out64, en64, in64, st64;
  logic         clr_we;

  assign out64 = 64'(out_r) & OMASK;
  assign en64  = 64'(en_r)  & IMASK;
  assign in64  = 64'(in_img) & IMASK;
  assign st64  = 64'(status) & IMASK;

  // next values for the word-written registers
  always_comb begin
    out_nx = out64;
    en_nx  = en64;
    sns_nx = 128'(sns_r);
    if (host_wr) begin
      case (host_addr)
        ADR_OUT_LO: out_nx[31:0]  = host_wdata;
        ADR_OUT_HI: out_nx[63:32] = host_wdata;
        ADR_EN_LO:  en_nx[31:0]   = host_wdata;
        ADR_EN_HI:  en_nx[63:32]  = host_wdata;
        default: begin
          if (host_addr >= ADR_SNS0 && host_addr <= ADR_SNS3)
            sns_nx[32*(host_addr - ADR_SNS0) +: 32] = host_wdata;
        end
      endcase
    end
  end

  assign clr_we = host_wr && (host_addr == ADR_ST_LO || host_addr == ADR_ST_HI);
  assign clr64  = (host_addr == ADR_ST_HI) ? {host_wdata, 32'd0} : {32'd0, host_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_r <= DIV_W'(DIV_RESET);
      out_r <= '0;
      en_r  <= '0;
      sns_r <= '0;
    end else begin
      if (host_wr && host_addr == ADR_DIV) div_r <= host_wdata[DIV_W-1:0];
      out_r <= OW'(out_nx);
      en_r  <= IW'(en_nx);
      sns_r <= (2*IW)'(sns_nx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          in_img <= '0;
    else if (frame_done) in_img <= cap_img;
  end

  always_comb begin
    case (host_addr)
      ADR_DIV:    host_rdata = 32'(div_r);
      ADR_OUT_LO: host_rdata = out64[31:0];
      ADR_OUT_HI: host_rdata = out64[63:32];
      ADR_IN_LO:  host_rdata = in64[31:0];
      ADR_IN_HI:  host_rdata = in64[63:32];
      ADR_EN_LO:  host_rdata = en64[31:0];
      ADR_EN_HI:  host_rdata = en64[63:32];
      ADR_ST_LO:  host_rdata = st64[31:0];
      ADR_ST_HI:  host_rdata = st64[63:32];
      default: begin
        if (host_addr >= ADR_SNS0 && host_addr <= ADR_SNS3)
          host_rdata = sns_r_ext[32*(host_addr - ADR_SNS0) +: 32];
        else
          host_rdata = '0;
      end
    endcase
  end

  logic [127:0] sns_r_ext;
  assign sns_r_ext = 128'(sns_r);

  sgx_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_period (div_r),
    .tick        (tick)
  );

  sgx_scan_engine #(.N_IN(N_IN), .N_OUT(N_OUT)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .out_img    (out_r),
    .ser_din    (ser_din),
    .ser_clk    (ser_clk),
    .ser_load_n (ser_load_n),
    .ser_dout   (ser_dout),
    .frame_done (frame_done),
    .cap_img    (cap_img)
  );

  sgx_irq_unit #(.N_IN(N_IN)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .img_new    (cap_img),
    .img_old    (in_img),
    .enable     (en_r),
    .sense      (sns_r),
    .clr_we     (clr_we),
    .clr_mask   (IW'(clr64)),
    .status     (status),
    .irq        (irq_o)
  );
endmodule

// File: rtl/serial_gpio_expander_chk.sv
module sgx_checker #(
  parameter int N_IN  = 16,
  parameter int N_OUT = 12
) (
  input logic clk,
  input logic rst_n,
  input logic host_wr,
  input logic ser_clk,
  input logic ser_load_n,
  input logic ser_dout,
  input logic irq_o
);
  localparam int LMX = (N_IN > N_OUT) ? N_IN : N_OUT;
  localparam int L   = (LMX > 0) ? LMX : 1;
  localparam int CW  = $clog2(L + 2);

  logic          clk_d, ld_d;
  logic [CW-1:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0;
      ld_d  <= 1'b0;
      rises <= '0;
    end else begin
      clk_d <= ser_clk;
      ld_d  <= ser_load_n;
      if (ld_d && !ser_load_n)     rises <= '0;
      else if (ser_clk && !clk_d)  rises <= rises + CW'(1);
    end
  end

  // R1: shift clock held low during the load/latch pulse
  a_r1_clk_low_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_load_n |-> !ser_clk);

  // R1: data never changes while the shift clock is high or rising
  a_r1_dout_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_dout));

  // R3: a segment between load pulses holds either no clock edges or exactly L
  a_r3_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_load_n) |-> (rises == '0 || rises == CW'(L)));

  // R9: interrupt stays up until the host writes
  a_r9_sticky_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_o) && !$past(host_wr)) |-> irq_o);
endmodule

bind serial_gpio_expander sgx_checker #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .ser_clk    (ser_clk),
  .ser_load_n (ser_load_n),
  .ser_dout   (ser_dout),
  .irq_o      (irq_o)
);

// File: tb/serial_gpio_expander_tb.sv
`timescale 1ns/1ps
module serial_gpio_expander_tb;
  localparam int N_IN  = 16;
  localparam int N_OUT = 12;
  localparam int L     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        ser_clk, ser_load_n, ser_dout, ser_din, irq_o;

  int vectors = 0;
  int fails   = 0;

  always #2.5 clk = ~clk;

  serial_gpio_expander #(.N_IN(N_IN), .N_OUT(N_OUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ser_clk(ser_clk),
    .ser_load_n(ser_load_n), .ser_dout(ser_dout), .ser_din(ser_din), .irq_o(irq_o)
  );

  // behavioural external chains, evaluated away from the active edge
  logic [N_IN-1:0]  pins = '0;
  logic [N_IN-1:0]  in_sr = '0;
  logic [N_OUT-1:0] out_sr = '0;
  logic [N_OUT-1:0] latch = '0;
  logic             sclk_p = 1'b0, ld_p = 1'b0;

  assign ser_din = in_sr[N_IN-1];

  always @(negedge clk) begin
    if (!ser_load_n)            in_sr <= pins;
    else if (ser_clk && !sclk_p) in_sr <= {in_sr[N_IN-2:0], 1'b0};
    if (ser_clk && !sclk_p)      out_sr <= {out_sr[N_OUT-2:0], ser_dout};
    if (ser_load_n && !ld_p)     latch <= out_sr;
    sclk_p <= ser_clk;
    ld_p   <= ser_load_n;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_frames(input int n);
    repeat (2 * n) @(negedge ser_load_n);
    repeat (3) @(negedge clk);
  endtask

  task automatic high_len(output int n);
    @(negedge clk);
    while (ser_clk)  @(negedge clk);
    while (!ser_clk) @(negedge clk);
    n = 0;
    while (ser_clk) begin n++; @(negedge clk); end
  endtask

  task automatic load_len(output int n);
    @(negedge clk);
    while (!ser_load_n) @(negedge clk);
    while (ser_load_n)  @(negedge clk);
    n = 0;
    while (!ser_load_n) begin n++; @(negedge clk); end
  endtask

  task automatic seg_rises(output int c);
    logic ps, pl;
    c = 0; ps = ser_clk; pl = ser_load_n;
    forever begin
      @(negedge clk);
      if (ser_clk && !ps) c++;
      if (!ser_load_n && pl) break;
      ps = ser_clk; pl = ser_load_n;
    end
  endtask

  function automatic logic [15:0] expect_st(input int r, input logic [15:0] p0,
                                            input logic [15:0] p1, input logic [15:0] en,
                                            input bit level_only);
    logic [15:0] e;
    for (int k = 0; k < 16; k++) begin
      case ((k + r) % 4)
        0: e[k] = level_only ? p1[k] : (p0[k] | p1[k]);
        1: e[k] = level_only ? ~p1[k] : (~p0[k] | ~p1[k]);
        2: e[k] = level_only ? 1'b0 : (~p0[k] & p1[k]);
        default: e[k] = level_only ? 1'b0 : (p0[k] & ~p1[k]);
      endcase
    end
    return e & en;
  endfunction

  initial begin
    #(5ns * 200000);
    fails++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, a, b;
    logic [15:0] p0s [2];
    logic [15:0] p1s [2];
    p0s[0] = 16'h3C5A; p1s[0] = 16'hA5C3;
    p0s[1] = 16'h0000; p1s[1] = 16'hFFFF;

    repeat (4) @(negedge clk);
    // R12: reset values
    chk("R12 ser_clk in reset", 64'(ser_clk), 64'd0);
    rst_n = 1'b1;
    rd(4'd0, d);  chk("R12 divider reset", 64'(d), 64'd2);
    rd(4'd1, d);  chk("R12 output reset", 64'(d), 64'd0);
    rd(4'd3, d);  chk("R12 input reset", 64'(d), 64'd0);
    rd(4'd11, d); chk("R12 status reset", 64'(d), 64'd0);
    chk("R12 irq reset", 64'(irq_o), 64'd0);

    // R2: phase length across divider settings (0 behaves as 1)
    for (int h = 0; h < 5; h++) begin
      wr(4'd0, 32'(h));
      wait_frames(1);
      high_len(n);
      chk($sformatf("R2 clock high length h=%0d", h), 64'(n), 64'(h == 0 ? 1 : h));
      load_len(n);
      chk($sformatf("R2 load pulse length h=%0d", h), 64'(n), 64'(h == 0 ? 1 : h));
    end

    // R3: clock edges per frame
    wr(4'd0, 32'd1);
    @(negedge ser_load_n);
    seg_rises(a); seg_rises(b);
    chk("R3 edges per frame", 64'(a + b), 64'(L));
    chk("R3 edges within one segment", 64'((a == L) || (b == L)), 64'd1);

    // R4 / R11: walking one, full pattern and overflow bits
    for (int k = 0; k < N_OUT; k++) begin
      wr(4'd1, 32'd1 << k);
      wait_frames(3);
      chk($sformatf("R4 latch walking bit %0d", k), 64'(latch), 64'(32'd1 << k));
    end
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd2, 32'hFFFF_FFFF);
    wait_frames(3);
    chk("R4 latch all ones", 64'(latch), 64'hFFF);
    rd(4'd1, d); chk("R11 output readback masked", 64'(d), 64'hFFF);
    rd(4'd2, d); chk("R11 output high word reads zero", 64'(d), 64'd0);
    wr(4'd1, 32'h0000_0A5C);
    wait_frames(3);
    chk("R4 latch pattern", 64'(latch), 64'hA5C);

    // R5: write during a shift lands one frame later
    wr(4'd0, 32'd4);
    wait_frames(2);
    @(posedge ser_clk);
    wr(4'd1, 32'h0000_03C1);
    @(negedge ser_load_n); @(posedge ser_load_n); repeat (3) @(negedge clk);
    chk("R5 current frame keeps old output", 64'(latch), 64'hA5C);
    @(negedge ser_load_n); @(posedge ser_load_n);
    @(negedge ser_load_n); @(posedge ser_load_n); repeat (3) @(negedge clk);
    chk("R5 next frame shows new output", 64'(latch), 64'h3C1);

    // R6: input capture with mid-frame change
    wr(4'd0, 32'd1);
    pins = 16'h8001;
    wait_frames(3);
    rd(4'd3, d); chk("R6 input image 8001", 64'(d), 64'h8001);
    rd(4'd4, d); chk("R6 input high word zero", 64'(d), 64'd0);
    pins = 16'h1234;
    wait_frames(3);
    rd(4'd3, d); chk("R6 input image 1234", 64'(d), 64'h1234);
    wr(4'd0, 32'd4);
    wait_frames(2);
    @(posedge ser_clk);
    pins = 16'hBEEF;
    @(negedge ser_load_n); @(negedge ser_load_n); repeat (3) @(negedge clk);
    rd(4'd3, d); chk("R6 image waits for complete frame", 64'(d), 64'h1234);
    @(negedge ser_load_n); @(negedge ser_load_n); repeat (3) @(negedge clk);
    rd(4'd3, d); chk("R6 image after next frame", 64'(d), 64'hBEEF);
    wr(4'd0, 32'd1);

    // R7 / R8 / R9 / R10: rotated sensitivities over two input pairs
    for (int r = 0; r < 4; r++) begin
      for (int pi = 0; pi < 2; pi++) begin
        logic [31:0] sw;
        logic [15:0] en, e;
        en = 16'hF7FF;
        sw = '0;
        for (int k = 0; k < 16; k++) sw[2*k +: 2] = 2'((k + r) % 4);
        wr(4'd5, 32'd0);
        pins = p0s[pi];
        wait_frames(3);
        wr(4'd7, sw);
        wr(4'd11, 32'hFFFF_FFFF);
        rd(4'd11, d);
        chk($sformatf("R8 disabled inputs set nothing r=%0d", r), 64'(d), 64'd0);
        wr(4'd5, 32'(en));
        wait_frames(2);
        pins = p1s[pi];
        wait_frames(3);
        e = expect_st(r, p0s[pi], p1s[pi], en, 1'b0);
        rd(4'd11, d);
        chk($sformatf("R7 status r=%0d pair=%0d", r, pi), 64'(d), 64'(e));
        rd(4'd12, d);
        chk("R11 status high word zero", 64'(d), 64'd0);
        chk($sformatf("R10 irq r=%0d pair=%0d", r, pi), 64'(irq_o), 64'(e != 0));
        wr(4'd11, 32'hFFFF_FFFF);
        wait_frames(2);
        e = expect_st(r, p0s[pi], p1s[pi], en, 1'b1);
        rd(4'd11, d);
        chk($sformatf("R9 after clear r=%0d pair=%0d", r, pi), 64'(d), 64'(e));
        chk($sformatf("R10 irq after clear r=%0d", r), 64'(irq_o), 64'(e != 0));
      end
    end

    // R9: partial clear of edge bits
    wr(4'd5, 32'd0);
    wr(4'd7, 32'hAAAA_AAAA);
    pins = 16'h0000;
    wait_frames(3);
    wr(4'd11, 32'hFFFF_FFFF);
    wr(4'd5, 32'h0000_FFFF);
    pins = 16'h00FF;
    wait_frames(3);
    wr(4'd11, 32'h0000_000F);
    rd(4'd11, d);
    chk("R9 partial write-one clear", 64'(d), 64'h00F0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule